// File: doc/BRIEF.md
# Oversampled Serial Character Receiver

This block recovers characters from an asynchronous serial line. An external baud generator supplies a tick at sixteen times the bit rate. The line idles high. A falling edge arms a half-bit check, and only a line that is still low at that point starts a frame. Each later bit is sampled once per sixteen ticks. A frame is a start bit, eight data bits sent least significant bit first, an optional parity bit of configurable sense, and one stop bit.

When a frame ends, the shifted character is copied into a holding register and a one-cycle completion pulse is raised. A frame with a parity, stop-bit or overrun fault still delivers its character. In that case the error pulse fires in the same cycle as the completion pulse, and the three status flags are rewritten. Dropping the receive enable, or asserting either mode-interlock input of a neighbouring clocked-serial function, stops a frame at once. The holding register and the flags are then left as they were, and no pulse is raised.

Top module: `serial_rx`

## Requirements
- R1: After reset, `data_o` is 0x00, all three error flags are 0, and neither interrupt output is high.
- R2: Reception runs only while `rx_en_i` is 1 and both `cs_tx_en_i` and `cs_rx_en_i` are 0. A frame sent while either interlock input is 1 raises no pulse and leaves `data_o` unchanged.
- R3: A falling edge is accepted as a start bit only if the line is still low 8 ticks later. A shorter low pulse is discarded, and the receiver then accepts the next proper frame.
- R4: The character is rebuilt least significant bit first, sampling the line once every 16 ticks after the start bit is confirmed. `data_o` equals the byte sent, for every byte value.
- R5: At the end of each frame, `data_o` is loaded and `done_irq_o` is high for exactly one clock cycle. `data_o` changes only in the cycle `done_irq_o` is high.
- R6: With `par_en_i`=1, a parity bit follows the data. `par_odd_i`=0 selects even parity and 1 selects odd parity. A mismatch sets `err_par_o` and still loads the data.
- R7: A stop bit sampled low sets `err_frm_o` and still loads the data.
- R8: A frame that completes while the previous character has not been acknowledged with `rd_ack_i` sets `err_ovr_o`. A completion after an acknowledge writes it back to 0.
- R9: `err_irq_o` is high exactly when `done_irq_o` is high and the frame has at least one fault. It is never high alone.
- R10: The error flags are written only at frame completion and hold their value between frames. `stat_clr_i` clears all three.
- R11: Clearing `rx_en_i` in the middle of a frame aborts it. No pulse is raised, and `data_o` and the flags keep their values. A later frame is received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversample tick, 16 per bit |
| rx_en_i | input | 1 | Receive enable |
| cs_tx_en_i | input | 1 | Clocked-serial transmit active (interlock) |
| cs_rx_en_i | input | 1 | Clocked-serial receive active (interlock) |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | 1 odd parity, 0 even parity |
| rxd_i | input | 1 | Serial line, idle high |
| rd_ack_i | input | 1 | Holding register read acknowledge |
| stat_clr_i | input | 1 | Clears error flags |
| data_o | output | 8 | Received character |
| err_par_o | output | 1 | Parity error flag |
| err_frm_o | output | 1 | Framing error flag |
| err_ovr_o | output | 1 | Overrun error flag |
| done_irq_o | output | 1 | Frame completion pulse |
| err_irq_o | output | 1 | Receive error pulse |

## Verification
All 256 byte values are sent, and the parity setting rotates through none, even and odd. This exposes bit-order, bit-count and sampling-phase faults, as well as parity sense errors on good frames. Separate frames carry a wrong parity bit, a low stop bit and an unacknowledged predecessor. Each of these must set only its own flag and fire both pulses together. A short low glitch tells a mid-bit start check apart from plain edge triggering. Frames sent with the block disabled, with an interlock input set, or cut off mid-frame show that nothing is written and no pulse is raised.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;
endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], d_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign q_o    = chain_q[STAGES-1];
  assign fall_o = prev_q & ~q_o;
endmodule

// File: rtl/serial_rx_fsm.sv
module serial_rx_fsm
  import serial_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              tick_i,
  input  logic              line_i,
  input  logic              fall_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  output logic              done_o,
  output logic [DATA_W-1:0] shift_o,
  output logic              par_err_o,
  output logic              frm_err_o
);
  localparam int unsigned CNT_W     = $clog2(OVS);
  localparam int unsigned IDX_W     = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OVS/2 - 1);
  localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OVS - 1);
  localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(DATA_W - 1);

  rx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] shift_q, shift_d;
  logic              acc_q, acc_d;
  logic              perr_q, perr_d;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    idx_d     = idx_q;
    shift_d   = shift_q;
    acc_d     = acc_q;
    perr_d    = perr_q;
    done_o    = 1'b0;
    frm_err_o = 1'b0;
    if (!active_i) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          cnt_d = '0;
          if (fall_i) state_d = ST_START;
        end
        ST_START: if (tick_i) begin
          if (cnt_q == HALF_LAST) begin
            cnt_d = '0;
            if (!line_i) begin
              state_d = ST_DATA;
              idx_d   = '0;
              acc_d   = 1'b0;
              perr_d  = 1'b0;
            end else begin
              state_d = ST_IDLE; // noise, rearm
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_DATA: if (tick_i) begin
          if (cnt_q == FULL_LAST) begin
            cnt_d   = '0;
            shift_d = {line_i, shift_q[DATA_W-1:1]};
            acc_d   = acc_q ^ line_i;
            if (idx_q == IDX_LAST) state_d = par_en_i ? ST_PAR : ST_STOP;
            else                   idx_d   = idx_q + 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_PAR: if (tick_i) begin
          if (cnt_q == FULL_LAST) begin
            cnt_d   = '0;
            perr_d  = acc_q ^ line_i ^ par_odd_i;
            state_d = ST_STOP;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_STOP: if (tick_i) begin
          if (cnt_q == FULL_LAST) begin
            cnt_d     = '0;
            done_o    = 1'b1;
            frm_err_o = ~line_i;
            state_d   = ST_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      shift_q <= '0;
      acc_q   <= 1'b0;
      perr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      shift_q <= shift_d;
      acc_q   <= acc_d;
      perr_q  <= perr_d;
    end
  end

  assign shift_o   = shift_q;
  assign par_err_o = perr_q;

  AST_START_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_START) |-> (cnt_q <= HALF_LAST)); // R3
  AST_ABORT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> (state_q == ST_IDLE)); // R11
  AST_NO_PAR_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PAR) |-> par_en_i || $past(par_en_i) || $past(state_q == ST_PAR)); // R6
endmodule

// File: rtl/serial_rx_buf.sv
module serial_rx_buf #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_err_i,
  input  logic              frm_err_i,
  input  logic              rd_ack_i,
  input  logic              stat_clr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              err_par_o,
  output logic              err_frm_o,
  output logic              err_ovr_o,
  output logic              done_irq_o,
  output logic              err_irq_o
);
  logic              load;
  logic              full_q;
  logic [DATA_W-1:0] data_q;
  logic [2:0]        flags_q;
  logic              done_q, err_q;

  assign load = load_i & active_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q  <= 1'b0;
      data_q  <= '0;
      flags_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= load;
      err_q  <= load & (par_err_i | frm_err_i | full_q);
      if (load) begin
        data_q  <= data_i;
        flags_q <= {full_q, frm_err_i, par_err_i};
        full_q  <= 1'b1;
      end else begin
        if (rd_ack_i)   full_q  <= 1'b0;
        if (stat_clr_i) flags_q <= '0;
      end
    end
  end

  assign data_o     = data_q;
  assign err_par_o  = flags_q[0];
  assign err_frm_o  = flags_q[1];
  assign err_ovr_o  = flags_q[2];
  assign done_irq_o = done_q;
  assign err_irq_o  = err_q;

  AST_ERR_NEEDS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_irq_o |-> done_irq_o); // R9
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_irq_o |=> !done_irq_o); // R5
  AST_DATA_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(data_o) |-> done_irq_o); // R5
  AST_IDLE_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> !done_irq_o && !err_irq_o); // R2
  AST_FLAGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(stat_clr_i) && !done_irq_o) |-> $stable({err_par_o, err_frm_o, err_ovr_o})); // R10
endmodule

// File: rtl/serial_rx.sv
module serial_rx #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OVS    = 16,
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_en_i,
  input  logic              cs_tx_en_i,
  input  logic              cs_rx_en_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              rxd_i,
  input  logic              rd_ack_i,
  input  logic              stat_clr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              err_par_o,
  output logic              err_frm_o,
  output logic              err_ovr_o,
  output logic              done_irq_o,
  output logic              err_irq_o
);
  logic              active;
  logic              line, fall;
  logic              done, perr, ferr;
  logic [DATA_W-1:0] shift;

  assign active = rx_en_i & ~cs_tx_en_i & ~cs_rx_en_i;

  serial_rx_sync #(.STAGES(SYNC_N)) i_sync (
    .clk_i, .rst_ni, .d_i(rxd_i), .q_o(line), .fall_o(fall)
  );

  serial_rx_fsm #(.DATA_W(DATA_W), .OVS(OVS)) i_fsm (
    .clk_i, .rst_ni, .active_i(active), .tick_i, .line_i(line), .fall_i(fall),
    .par_en_i, .par_odd_i, .done_o(done), .shift_o(shift),
    .par_err_o(perr), .frm_err_o(ferr)
  );

  serial_rx_buf #(.DATA_W(DATA_W)) i_buf (
    .clk_i, .rst_ni, .active_i(active), .load_i(done), .data_i(shift),
    .par_err_i(perr), .frm_err_i(ferr), .rd_ack_i, .stat_clr_i,
    .data_o, .err_par_o, .err_frm_o, .err_ovr_o, .done_irq_o, .err_irq_o
  );
endmodule

// File: tb/test_serial_rx.sv
`timescale 1ns/1ps
module test_serial_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_en = 1'b0, cs_tx = 1'b0, cs_rx = 1'b0;
  logic par_en = 1'b0, par_odd = 1'b0, rxd = 1'b1, rd_ack = 1'b0, stat_clr = 1'b0;
  logic [7:0] data;
  logic ep, ef, eo, done_irq, err_irq;
  int n_vec = 0, n_fail = 0;
  int n_done = 0, n_err = 0, n_err_alone = 0;

  always #2.5 clk = ~clk;

  serial_rx i_serial_rx (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(1'b1), .rx_en_i(rx_en),
    .cs_tx_en_i(cs_tx), .cs_rx_en_i(cs_rx), .par_en_i(par_en), .par_odd_i(par_odd),
    .rxd_i(rxd), .rd_ack_i(rd_ack), .stat_clr_i(stat_clr),
    .data_o(data), .err_par_o(ep), .err_frm_o(ef), .err_ovr_o(eo),
    .done_irq_o(done_irq), .err_irq_o(err_irq)
  );

  always @(negedge clk) if (rst_n) begin
    if (done_irq) n_done++;
    if (err_irq) begin
      n_err++;
      if (!done_irq) n_err_alone++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bit_slot(input logic v);
    rxd = v;
    repeat (16) @(negedge clk);
  endtask

  // pmode: 0 none, 1 even, 2 odd
  task automatic frame(input logic [7:0] b, input int pmode, input bit bad_par, input logic stop_v);
    par_en  = (pmode != 0);
    par_odd = (pmode == 2);
    bit_slot(1'b0);
    for (int i = 0; i < 8; i++) bit_slot(b[i]);
    if (pmode != 0) bit_slot((pmode == 2 ? ~^b : ^b) ^ bad_par);
    bit_slot(stop_v);
    rxd = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic pulse_ack();
    rd_ack = 1'b1; @(negedge clk); rd_ack = 1'b0;
  endtask

  task automatic pulse_clr();
    stat_clr = 1'b1; @(negedge clk); stat_clr = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int d0, e0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 data", data, 0);
    chk("R1 flags", {ep, ef, eo}, 0);
    chk("R1 irqs", {done_irq, err_irq}, 0);

    // R2 interlock blocks reception; disabled blocks reception
    rx_en = 1'b1; cs_tx = 1'b1;
    frame(8'h5A, 0, 0, 1'b1);
    chk("R2 cs_tx no done", n_done, 0);
    chk("R2 cs_tx data", data, 0);
    cs_tx = 1'b0; cs_rx = 1'b1;
    frame(8'hC3, 1, 0, 1'b1);
    chk("R2 cs_rx no done", n_done, 0);
    chk("R2 cs_rx data", data, 0);
    cs_rx = 1'b0; rx_en = 1'b0;
    frame(8'h3C, 0, 0, 1'b1);
    chk("R2 disabled no irq", n_done + n_err, 0);
    rx_en = 1'b1;

    // R3 short glitch rejected, then a real frame
    rxd = 1'b0; repeat (4) @(negedge clk); rxd = 1'b1;
    repeat (40) @(negedge clk);
    chk("R3 glitch no done", n_done, 0);
    frame(8'hA5, 0, 0, 1'b1);
    chk("R3 frame after glitch", n_done, 1);
    chk("R3 data after glitch", data, 'hA5);
    pulse_ack();

    // R4/R5/R6 sweep all bytes, rotating parity mode
    for (int b = 0; b < 256; b++) begin
      d0 = n_done; e0 = n_err;
      frame(8'(b), b % 3, 0, 1'b1);
      chk("R5 one done pulse", n_done - d0, 1);
      chk("R4 data", data, b);
      chk("R6 good frame flags", {ep, ef, eo}, 0);
      chk("R9 no err irq", n_err - e0, 0);
      pulse_ack();
    end

    // R6 parity mismatch (even, then odd)
    d0 = n_done; e0 = n_err;
    frame(8'h11, 1, 1, 1'b1);
    chk("R6 even bad data", data, 'h11);
    chk("R6 even bad flags", {eo, ef, ep}, 3'b001);
    chk("R9 err with done", n_err - e0, 1);
    chk("R9 done count", n_done - d0, 1);
    pulse_ack();
    repeat (60) @(negedge clk);
    chk("R10 flag holds", ep, 1);
    pulse_clr(); @(negedge clk);
    chk("R10 cleared", {ep, ef, eo}, 0);
    frame(8'hE7, 2, 1, 1'b1);
    chk("R6 odd bad flags", {eo, ef, ep}, 3'b001);
    chk("R6 odd bad data", data, 'hE7);
    pulse_ack(); pulse_clr();

    // R7 framing error
    e0 = n_err;
    frame(8'h42, 0, 0, 1'b0);
    chk("R7 frm flags", {eo, ef, ep}, 3'b010);
    chk("R7 frm data", data, 'h42);
    chk("R9 frm err irq", n_err - e0, 1);
    pulse_ack(); pulse_clr();

    // R8 overrun
    frame(8'h01, 0, 0, 1'b1);
    e0 = n_err;
    frame(8'h02, 0, 0, 1'b1);
    chk("R8 ovr flags", {eo, ef, ep}, 3'b100);
    chk("R8 ovr data", data, 'h02);
    chk("R9 ovr err irq", n_err - e0, 1);
    pulse_ack();
    frame(8'h03, 0, 0, 1'b1);
    chk("R8 ovr rewritten", eo, 0);
    pulse_ack();

    // R11 abort mid-frame keeps buffer and flags
    frame(8'h99, 1, 1, 1'b1);
    pulse_ack();
    d0 = n_done; e0 = n_err;
    par_en = 1'b0;
    bit_slot(1'b0);
    for (int i = 0; i < 3; i++) bit_slot(1'b1);
    rx_en = 1'b0;
    for (int i = 3; i < 8; i++) bit_slot(1'b0);
    bit_slot(1'b1);
    repeat (10) @(negedge clk);
    chk("R11 no irq", (n_done - d0) + (n_err - e0), 0);
    chk("R11 data kept", data, 'h99);
    chk("R11 flags kept", {eo, ef, ep}, 3'b001);
    rx_en = 1'b1;
    repeat (5) @(negedge clk);
    frame(8'h6E, 0, 0, 1'b1);
    chk("R11 recovers", data, 'h6E);
    chk("R9 never alone", n_err_alone, 0);
    summary();
  end
endmodule